// File: doc/BRIEF.md
# Deferred Configuration Update Window

This block holds a bank of configuration registers, each kept as a shadow copy and a live copy. An upstream bus interface writes the shadow copies. It raises a separate commit trigger at the moment a write is considered final. For a serial transfer, that moment is the clock edge of the last data bit. For a pin-driven interface, it is the pin transition. The live copies drive the rest of the chip.

A commit to an idle register applies the shadow value to the live output at once. It also opens a settling window whose length is a per-register parameter, counted in system clock cycles. While the window is open, the register reports busy. Further writes only refresh the shadow copy, and further commits are ignored. When the window runs out, the live output picks up whatever the shadow holds at that moment. This includes a write landing on the expiry clock itself.

Top module: `cfg_delay_window`

## Requirements
- R1: After reset every live value equals its parameter default (register 0..4 default A0, B1, C2, D3, E4 hex) and every busy bit is 0.
- R2: A write with no commit to a register whose window is closed leaves its live value and busy bit unchanged.
- R3: A commit to a register whose window is closed makes its live value equal to its shadow value on the next cycle and sets its busy bit. If a write to the same register comes in the same cycle, that write's data is the value used.
- R4: After such a commit, busy stays high for exactly DELAY cycles and is low on the cycle after (default DELAY per register 0..4: 1, 3, 5, 9, 2).
- R5: While a window is open, writes change only the shadow copy; the live value holds.
- R6: A commit while a window is open neither restarts nor lengthens that window.
- R7: On the cycle busy falls, the live value equals the last value written before or during the window.
- R8: A write on the same clock as window expiry is the value the live output takes.
- R9: Registers are independent: a write or commit to one register leaves the others' live values and busy bits unchanged.
- R10: A write or commit index of NUM_REGS or above has no effect on any register, including its shadow copy.
- R11: A commit after a window has closed applies immediately and opens a new full window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Shadow write strobe |
| wr_idx | input | IDX_W (3) | Register index of the write |
| wr_data | input | DATA_W (8) | Write data |
| commit_en | input | 1 | Commit trigger |
| commit_idx | input | IDX_W (3) | Register index of the commit |
| live_flat | output | NUM_REGS*DATA_W (40) | Live values; register i occupies bits i*DATA_W upward |
| busy | output | NUM_REGS (5) | Bit i is high while register i's window is open |

## Verification
Each input drive causes a register update, and every result appears after exactly one clock edge. A commit's new value and its busy flag are due one cycle after the drive. Busy clears, and the expiry value appears, DELAY cycles after that. The driver computes the due cycle of each expected live/busy pair from the register's delay and queues it with that cycle number. The monitor samples a few nanoseconds after each rising edge and compares only the items due in that cycle. Items still left in the queue at the end count as failures.

// File: rtl/cfg_dly_pkg.sv
package cfg_dly_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_OPEN = 2'd1,
        SLOT_LAST = 2'd2
    } slot_phase_e;

    // Classify a remaining-cycle count into the phase of its window.
    function automatic slot_phase_e phase_of(input logic [31:0] remain);
        if (remain == 32'd0)      return SLOT_IDLE;
        else if (remain == 32'd1) return SLOT_LAST;
        else                      return SLOT_OPEN;
    endfunction

endpackage

// File: rtl/cfg_dly_decode.sv
module cfg_dly_decode #(
    parameter int NUM_REGS = 5,
    parameter int IDX_W    = 3
) (
    input  logic                en,
    input  logic [IDX_W-1:0]    idx,
    output logic [NUM_REGS-1:0] hit
);

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_sel
            assign hit[g] = en && (idx == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        assert_sel_onehot_R9: assert ($onehot0(hit));
        if (en && (32'(idx) >= NUM_REGS)) begin
            assert_range_ignored_R10: assert (hit == '0);
        end
    end

endmodule

// File: rtl/cfg_dly_slot.sv
module cfg_dly_slot #(
    parameter int              DATA_W    = 8,
    parameter int              CNT_W     = 8,
    parameter int              DELAY     = 3,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit_hit,
    output logic [DATA_W-1:0] live,
    output logic              busy
);
    import cfg_dly_pkg::*;

    localparam logic [CNT_W-1:0] WIN_LEN = CNT_W'(DELAY);

    typedef struct packed {
        logic [DATA_W-1:0] shadow;
        logic [DATA_W-1:0] live;
        logic [CNT_W-1:0]  remain;
    } slot_t;

    slot_t       st_q;
    slot_t       st_d;
    slot_phase_e phase_d;

    always_comb begin
        st_d        = st_q;
        st_d.shadow = wr_hit ? wr_data : st_q.shadow;
        phase_d     = phase_of(32'(st_q.remain));
        case (phase_d)
            SLOT_IDLE: begin
                if (commit_hit) begin
                    st_d.live   = st_d.shadow;
                    st_d.remain = WIN_LEN;
                end
            end
            SLOT_OPEN: begin
                st_d.remain = st_q.remain - 1'b1;
            end
            SLOT_LAST: begin
                st_d.remain = '0;
                st_d.live   = st_d.shadow;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shadow <= RESET_VAL;
            st_q.live   <= RESET_VAL;
            st_q.remain <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live = st_q.live;
    assign busy = (st_q.remain != '0);

    assert_idle_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.remain == '0 && !commit_hit) |=> ($stable(st_q.live) && st_q.remain == '0));

    assert_idle_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.remain == '0 && commit_hit) |=> (st_q.live == st_q.shadow && st_q.remain == WIN_LEN));

    assert_open_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.remain > CNT_W'(1)) |=> $stable(st_q.live));

    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.remain != '0) |=> (st_q.remain == $past(st_q.remain) - 1'b1));

    assert_expiry_apply_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.remain == CNT_W'(1)) |=> (st_q.live == st_q.shadow && st_q.remain == '0));

endmodule

// File: rtl/cfg_delay_window.sv
module cfg_delay_window #(
    parameter int NUM_REGS = 5,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 8,
    parameter logic [NUM_REGS*CNT_W-1:0]  DELAYS   = {8'd2, 8'd9, 8'd5, 8'd3, 8'd1},
    parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = {8'hE4, 8'hD3, 8'hC2, 8'hB1, 8'hA0},
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS + 1) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         commit_en,
    input  logic [IDX_W-1:0]             commit_idx,
    output logic [NUM_REGS*DATA_W-1:0]   live_flat,
    output logic [NUM_REGS-1:0]          busy
);

    logic [NUM_REGS-1:0] wr_sel;
    logic [NUM_REGS-1:0] commit_sel;

    cfg_dly_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_wr_dec (
        .en  (wr_en),
        .idx (wr_idx),
        .hit (wr_sel)
    );

    cfg_dly_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_commit_dec (
        .en  (commit_en),
        .idx (commit_idx),
        .hit (commit_sel)
    );

    genvar r;
    generate
        for (r = 0; r < NUM_REGS; r++) begin : g_slot
            cfg_dly_slot #(
                .DATA_W    (DATA_W),
                .CNT_W     (CNT_W),
                .DELAY     (int'(DELAYS[r*CNT_W +: CNT_W])),
                .RESET_VAL (DEFAULTS[r*DATA_W +: DATA_W])
            ) i_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_hit     (wr_sel[r]),
                .wr_data    (wr_data),
                .commit_hit (commit_sel[r]),
                .live       (live_flat[r*DATA_W +: DATA_W]),
                .busy       (busy[r])
            );
        end
    endgenerate

endmodule

// File: tb/test_cfg_delay_window.sv
module test_cfg_delay_window;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [7:0]  wr_data;
    logic        commit_en;
    logic [2:0]  commit_idx;
    logic [39:0] live_flat;
    logic [4:0]  busy;

    always #10 clk = ~clk;

    cfg_delay_window i_cfg_delay_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .commit_en  (commit_en),
        .commit_idx (commit_idx),
        .live_flat  (live_flat),
        .busy       (busy)
    );

    typedef struct {
        int         due;
        int         idx;
        logic [7:0] val;
        logic       bsy;
        string      req;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_err = 0;
    logic [7:0] dflt [5] = '{8'hA0, 8'hB1, 8'hC2, 8'hD3, 8'hE4};

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void want(int due, int idx, logic [7:0] v, logic b, string req);
        exp_t e;
        e.due = due; e.idx = idx; e.val = v; e.bsy = b; e.req = req;
        sb.push_back(e);
    endfunction

    task automatic check_now(int idx, logic [7:0] v, logic b, string req);
        logic [7:0] act_v;
        act_v = live_flat[idx*8 +: 8];
        n_checks++;
        if (act_v !== v || busy[idx] !== b) begin
            n_err++;
            $display("FAIL %s reg%0d cycle %0d: live=%h busy=%b expected live=%h busy=%b",
                     req, idx, cyc, act_v, busy[idx], v, b);
        end
    endtask

    // Monitor: compares queued items whose due cycle has come.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            for (int k = sb.size() - 1; k >= 0; k--) begin
                if (sb[k].due == cyc) begin
                    check_now(sb[k].idx, sb[k].val, sb[k].bsy, sb[k].req);
                    sb.delete(k);
                end
            end
        end
    end

    // Drive one cycle of inputs from a falling edge; results due at cyc+1.
    task automatic step(logic w, int wi, logic [7:0] wd, logic c, int ci);
        wr_en      = w;
        wr_idx     = 3'(wi);
        wr_data    = wd;
        commit_en  = c;
        commit_idx = 3'(ci);
        @(negedge clk);
        wr_en     = 1'b0;
        commit_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #100000;
        n_err++;
        $display("FAIL watchdog: run did not finish, cycle %0d expected end", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int t;
        int t5;
        rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        commit_en = 1'b0; commit_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 5; i++) check_now(i, dflt[i], 1'b0, "R1");

        // R2: write without commit stays in shadow
        t = cyc;
        want(t + 1, 1, 8'hB1, 1'b0, "R2");
        want(t + 3, 1, 8'hB1, 1'b0, "R2");
        step(1'b1, 1, 8'h11, 1'b0, 0);
        idle(3);

        // R3/R4: commit alone applies the stored shadow, busy for 3 cycles
        t = cyc;
        want(t + 1, 1, 8'h11, 1'b1, "R3");
        want(t + 3, 1, 8'h11, 1'b1, "R4");
        want(t + 4, 1, 8'h11, 1'b0, "R4");
        step(1'b0, 0, 8'h00, 1'b1, 1);
        idle(4);

        // R5/R6/R7: writes and a commit inside the open window of reg 2
        t = cyc;
        want(t + 1, 2, 8'h30, 1'b1, "R3");
        want(t + 2, 2, 8'h30, 1'b1, "R5");
        want(t + 3, 2, 8'h30, 1'b1, "R5");
        want(t + 5, 2, 8'h30, 1'b1, "R6");
        want(t + 6, 2, 8'h32, 1'b0, "R6");
        want(t + 6, 2, 8'h32, 1'b0, "R7");
        step(1'b1, 2, 8'h30, 1'b1, 2);
        step(1'b1, 2, 8'h31, 1'b0, 0);
        step(1'b1, 2, 8'h32, 1'b1, 2);
        idle(5);

        // R8: write on the expiry clock of reg 3 (delay 9)
        t = cyc;
        want(t + 1, 3, 8'h40, 1'b1, "R3");
        want(t + 9, 3, 8'h40, 1'b1, "R8");
        want(t + 10, 3, 8'h4F, 1'b0, "R8");
        step(1'b1, 3, 8'h40, 1'b1, 3);
        idle(8);
        step(1'b1, 3, 8'h4F, 1'b0, 0);

        // R11: commit right after the window closed
        t5 = cyc;
        want(t5 + 1, 3, 8'h55, 1'b1, "R11");
        want(t5 + 9, 3, 8'h55, 1'b1, "R11");
        want(t5 + 10, 3, 8'h55, 1'b0, "R7");
        step(1'b1, 3, 8'h55, 1'b1, 3);

        // R9: independence while reg 3 is busy
        t = cyc;
        want(t + 1, 0, 8'h66, 1'b1, "R9");
        want(t + 1, 3, 8'h55, 1'b1, "R9");
        want(t + 1, 4, 8'hE4, 1'b0, "R9");
        want(t + 2, 0, 8'h66, 1'b0, "R4");
        step(1'b1, 0, 8'h66, 1'b1, 0);
        idle(1);

        // R10: out-of-range indices touch nothing, not even a shadow
        t = cyc;
        want(t + 1, 4, 8'hE4, 1'b0, "R10");
        want(t + 1, 0, 8'h66, 1'b0, "R10");
        want(t + 2, 4, 8'hE4, 1'b0, "R10");
        want(t + 3, 4, 8'hE4, 1'b1, "R10");
        step(1'b1, 7, 8'h77, 1'b1, 6);
        step(1'b1, 5, 8'h78, 1'b1, 5);
        step(1'b0, 0, 8'h00, 1'b1, 4);

        idle(12);
        if (sb.size() != 0) begin
            n_err += sb.size();
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule